// File: doc/BRIEF.md
# Page Class Key Permission Checker

This block applies a second layer of page protection on top of the permissions a translation unit has already derived from a page's protection bits. Each page table entry carries a 5-bit class key. The key selects a 2-bit read/write enable pair from a 64-bit access-mask register. The resulting key permission set is ANDed with the incoming protection-bit permission set to give the final read/write/execute permissions. A fault is flagged in the same cycle when the access in hand needs a permission that the final set lacks.

On a faulting request, the block records the cause one cycle later. A data-side fault loads a status word that separates the causes: protection-bit denial, store access and key denial are each reported on their own bit. The same fault also captures the effective address. An instruction-fetch fault loads only a fixed error code. The page table walk, the segment lookup and the decode of the protection bits all happen upstream, so the protection-bit result arrives here as a 3-bit input.

Top module: `pck_top`

## Requirements
- R1: The class key is {pteWord[61:60], pteWord[11:9]}: entry bits 61:60 give key bits 4:3 and entry bits 11:9 give key bits 2:0. No other entry bit has any effect.
- R2: For key k, the enable pair is maskReg[2*(31-k)+1 : 2*(31-k)], so key 0 uses bits 63:62. The upper bit of the pair grants write and the lower bit grants read.
- R3: Execute permission is never removed by the key check. With keyEnable low, the key check grants read, write and execute whatever the mask holds.
- R4: permOut is ppPerm AND the key permission set, in the encoding bit0 = read, bit1 = write, bit2 = execute. This applies to both permOut and ppPerm.
- R5: faultNow is high, in the same cycle, exactly when reqValid is high, accessType is not 3, and permOut lacks the required permission. accessType 0 = load needs read, 1 = store needs write, 2 = fetch needs execute, and 3 = no access, which needs nothing.
- R6: On a valid data-side fault (load or store), dataStatus becomes the OR of three terms after the next rising clock edge: 0x08000000 if ppPerm lacks the required permission, 0x02000000 if the access is a store, and 0x00200000 if the key set lacks the required permission.
- R7: On a valid data-side fault, faultAddr takes effAddr after the next rising edge, and errCode becomes 0.
- R8: On a valid fetch fault, errCode becomes 0x08000000 after the next rising edge, while dataStatus and faultAddr keep their values.
- R9: When faultNow is low, errCode, dataStatus and faultAddr hold their values.
- R10: An asynchronous active-low reset clears errCode, dataStatus and faultAddr to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| keyEnable | input | 1 | Enables the class key check |
| reqValid | input | 1 | A translation request is present |
| accessType | input | 2 | 0 load, 1 store, 2 fetch, 3 none |
| pteWord | input | 64 | Second doubleword of the page table entry |
| maskReg | input | 64 | Access-mask register, two bits per key |
| ppPerm | input | 3 | Permissions from the protection bits (bit0 R, bit1 W, bit2 X) |
| effAddr | input | 64 | Effective address of the request |
| permOut | output | 3 | Final permission set |
| faultNow | output | 1 | Access violation in this cycle |
| errCode | output | 32 | Registered error code of the last fault |
| dataStatus | output | 32 | Registered status word of the last data fault |
| faultAddr | output | 64 | Registered address of the last data fault |

## Verification
The assertions check several properties on every cycle. The final permissions never exceed the protection-bit set, and execute passes through unchanged. A fault only ever comes with a valid request. Fetch faults and quiet cycles leave the data fault registers alone. A store fault sets the store bit, and the captured address matches the faulting request. Only the bench's scenarios can show the key-dependent results. These are the extraction of the key from the split entry fields, the selection of the right mask pair across all 32 keys, and the exact composition of the status word for each mix of causes.

// File: rtl/pck_pkg.sv
package pck_pkg;
  localparam int PERM_W = 3;
  localparam int RD_BIT = 0;
  localparam int WR_BIT = 1;
  localparam int EX_BIT = 2;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_NONE  = 2'd3
  } acc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              capData;
    logic              capFetch;
    logic [PERM_W-1:0] need;
  } strobe_t;

  localparam logic [31:0] ST_PP_DENY  = 32'h0800_0000;
  localparam logic [31:0] ST_STORE    = 32'h0200_0000;
  localparam logic [31:0] ST_KEY_DENY = 32'h0020_0000;
  localparam logic [31:0] FETCH_CODE  = 32'h0800_0000;
endpackage

// File: rtl/pck_ctrl.sv
module pck_ctrl
  import pck_pkg::*;
(
  input  logic              reqValid,
  input  logic [1:0]        accessType,
  input  logic [PERM_W-1:0] permOut,
  output strobe_t           strobes,
  output logic              faultNow
);
  acc_e accKind;
  logic [PERM_W-1:0] needPerm;

  always_comb begin
    accKind  = acc_e'(accessType);
    needPerm = '0;
    unique case (accKind)
      ACC_LOAD:  needPerm[RD_BIT] = 1'b1;
      ACC_STORE: needPerm[WR_BIT] = 1'b1;
      ACC_FETCH: needPerm[EX_BIT] = 1'b1;
      default:   needPerm = '0;
    endcase
  end

  always_comb begin
    faultNow          = reqValid && ((needPerm & ~permOut) != '0);
    strobes.need      = needPerm;
    strobes.capFetch  = faultNow && (accKind == ACC_FETCH);
    strobes.capData   = faultNow && (accKind != ACC_FETCH);
  end
endmodule

// File: rtl/pck_dp.sv
module pck_dp
  import pck_pkg::*;
#(
  parameter int KEY_W      = 5,
  parameter int KEY_LO_W   = 3,
  parameter int KEY_LO_LSB = 9,
  parameter int KEY_HI_LSB = 60,
  parameter int PTE_W      = 64,
  parameter int ADDR_W     = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              keyEnable,
  input  logic [PTE_W-1:0]  pteWord,
  input  logic [2*(1<<KEY_W)-1:0] maskReg,
  input  logic [PERM_W-1:0] ppPerm,
  input  logic [ADDR_W-1:0] effAddr,
  input  strobe_t           strobes,
  output logic [PERM_W-1:0] permOut,
  output logic [31:0]       errCode,
  output logic [31:0]       dataStatus,
  output logic [ADDR_W-1:0] faultAddr
);
  localparam int NUM_KEYS = 1 << KEY_W;
  localparam int KEY_HI_W = KEY_W - KEY_LO_W;

  logic [KEY_W-1:0]  keyIdx;
  logic [1:0]        keyPairs [NUM_KEYS];
  logic [1:0]        selPair;
  logic [PERM_W-1:0] keyPerm;
  logic [31:0]       statusNext;

  assign keyIdx = {pteWord[KEY_HI_LSB +: KEY_HI_W], pteWord[KEY_LO_LSB +: KEY_LO_W]};

  // key 0 owns the most significant pair
  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_pair
    assign keyPairs[k] = maskReg[2*(NUM_KEYS-1-k) +: 2];
  end

  assign selPair = keyPairs[keyIdx];

  always_comb begin
    keyPerm = '1;
    if (keyEnable) begin
      keyPerm[RD_BIT] = selPair[0];
      keyPerm[WR_BIT] = selPair[1];
    end
    permOut = ppPerm & keyPerm;
  end

  always_comb begin
    statusNext = '0;
    if ((strobes.need & ~ppPerm) != '0)  statusNext |= ST_PP_DENY;
    if (strobes.need[WR_BIT])            statusNext |= ST_STORE;
    if ((strobes.need & ~keyPerm) != '0) statusNext |= ST_KEY_DENY;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errCode    <= '0;
      dataStatus <= '0;
      faultAddr  <= '0;
    end else if (strobes.capData) begin
      errCode    <= '0;
      dataStatus <= statusNext;
      faultAddr  <= effAddr;
    end else if (strobes.capFetch) begin
      errCode    <= FETCH_CODE;
    end
  end

  // R4: final permissions never exceed the protection-bit set
  a_r4_subset_of_pp: assert property (@(posedge clk) disable iff (!rstN)
    (permOut & ~ppPerm) == '0);

  // R3: execute passes through untouched by the key check
  a_r3_exec_kept: assert property (@(posedge clk) disable iff (!rstN)
    permOut[EX_BIT] == ppPerm[EX_BIT]);

  // R3: with the check disabled, permissions equal the protection set
  a_r3_disabled_passes: assert property (@(posedge clk) disable iff (!rstN)
    !keyEnable |-> permOut == ppPerm);
endmodule

// File: rtl/pck_top.sv
module pck_top
  import pck_pkg::*;
#(
  parameter int KEY_W  = 5,
  parameter int PTE_W  = 64,
  parameter int ADDR_W = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    keyEnable,
  input  logic                    reqValid,
  input  logic [1:0]              accessType,
  input  logic [PTE_W-1:0]        pteWord,
  input  logic [2*(1<<KEY_W)-1:0] maskReg,
  input  logic [PERM_W-1:0]       ppPerm,
  input  logic [ADDR_W-1:0]       effAddr,
  output logic [PERM_W-1:0]       permOut,
  output logic                    faultNow,
  output logic [31:0]             errCode,
  output logic [31:0]             dataStatus,
  output logic [ADDR_W-1:0]       faultAddr
);
  strobe_t strobes;

  pck_ctrl ctrl_i (
    .reqValid  (reqValid),
    .accessType(accessType),
    .permOut   (permOut),
    .strobes   (strobes),
    .faultNow  (faultNow)
  );

  pck_dp #(
    .KEY_W (KEY_W),
    .PTE_W (PTE_W),
    .ADDR_W(ADDR_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .keyEnable (keyEnable),
    .pteWord   (pteWord),
    .maskReg   (maskReg),
    .ppPerm    (ppPerm),
    .effAddr   (effAddr),
    .strobes   (strobes),
    .permOut   (permOut),
    .errCode   (errCode),
    .dataStatus(dataStatus),
    .faultAddr (faultAddr)
  );

  // R5: a fault only accompanies a valid request
  a_r5_fault_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    faultNow |-> reqValid);

  // R9: quiet cycles leave every fault register alone
  a_r9_hold_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !faultNow |=> $stable(errCode) && $stable(dataStatus) && $stable(faultAddr));

  // R8: fetch faults keep data fault state and load the fetch code
  a_r8_fetch_keeps_data: assert property (@(posedge clk) disable iff (!rstN)
    (faultNow && accessType == 2'd2) |=>
      $stable(dataStatus) && $stable(faultAddr) && errCode == FETCH_CODE);

  // R7: data fault captures the request address
  a_r7_addr_capture: assert property (@(posedge clk) disable iff (!rstN)
    (faultNow && accessType != 2'd2) |=> faultAddr == $past(effAddr) && errCode == '0);

  // R6: a store fault always reports the store bit
  a_r6_store_bit: assert property (@(posedge clk) disable iff (!rstN)
    (faultNow && accessType == 2'd1) |=> dataStatus[25]);
endmodule

// File: tb/pck_top_tb_top.sv
module pck_top_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        en;
    logic        valid;
    logic [1:0]  acc;
    logic [4:0]  key;
    logic [1:0]  pair;
    logic        fill;
    logic [2:0]  pp;
    logic [63:0] addr;
    logic [2:0]  expPerm;
    logic        expFault;
    logic [31:0] expStatus;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,2'd0,5'd0 ,2'b01,1'b0,3'b111,64'h0000_0000_0000_1000,3'b101,1'b0,32'h0},
    '{1'b1,1'b1,2'd1,5'd0 ,2'b01,1'b0,3'b111,64'h0000_0000_0000_2008,3'b101,1'b1,32'h0220_0000},
    '{1'b1,1'b1,2'd0,5'd31,2'b10,1'b1,3'b111,64'hDEAD_0000_0000_3010,3'b110,1'b1,32'h0020_0000},
    '{1'b1,1'b1,2'd1,5'd13,2'b11,1'b0,3'b101,64'h0000_BEEF_0000_4018,3'b101,1'b1,32'h0A00_0000},
    '{1'b1,1'b1,2'd2,5'd5 ,2'b00,1'b0,3'b111,64'h0000_0000_0000_5020,3'b100,1'b0,32'h0},
    '{1'b1,1'b1,2'd2,5'd5 ,2'b11,1'b1,3'b011,64'h0000_0000_0000_6028,3'b011,1'b1,32'h0},
    '{1'b0,1'b1,2'd1,5'd7 ,2'b00,1'b0,3'b111,64'h0000_0000_0000_7030,3'b111,1'b0,32'h0},
    '{1'b0,1'b1,2'd0,5'd7 ,2'b00,1'b1,3'b010,64'h1234_5678_0000_8038,3'b010,1'b1,32'h0800_0000},
    '{1'b1,1'b0,2'd1,5'd0 ,2'b00,1'b0,3'b000,64'h0000_0000_0000_9040,3'b000,1'b0,32'h0},
    '{1'b1,1'b1,2'd3,5'd0 ,2'b00,1'b0,3'b000,64'h0000_0000_0000_A048,3'b000,1'b0,32'h0},
    '{1'b1,1'b1,2'd0,5'd24,2'b01,1'b1,3'b111,64'h0000_0000_0000_B050,3'b101,1'b0,32'h0},
    '{1'b1,1'b1,2'd1,5'd24,2'b01,1'b1,3'b111,64'hFFFF_0000_0000_C058,3'b101,1'b1,32'h0220_0000},
    '{1'b1,1'b1,2'd1,5'd7 ,2'b10,1'b1,3'b111,64'h0000_0000_0000_D060,3'b110,1'b0,32'h0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        keyEnable = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  accessType = 2'd3;
  logic [63:0] pteWord = '0;
  logic [63:0] maskReg = '0;
  logic [2:0]  ppPerm = '0;
  logic [63:0] effAddr = '0;
  logic [2:0]  permOut;
  logic        faultNow;
  logic [31:0] errCode;
  logic [31:0] dataStatus;
  logic [63:0] faultAddr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [31:0] expErr = '0;
  logic [31:0] expStatus = '0;
  logic [63:0] expAddr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pck_top dut_i (
    .clk(clk), .rstN(rstN), .keyEnable(keyEnable), .reqValid(reqValid),
    .accessType(accessType), .pteWord(pteWord), .maskReg(maskReg),
    .ppPerm(ppPerm), .effAddr(effAddr), .permOut(permOut), .faultNow(faultNow),
    .errCode(errCode), .dataStatus(dataStatus), .faultAddr(faultAddr)
  );

  function automatic logic [63:0] mkPte(input logic [4:0] k, input logic noise);
    logic [63:0] w;
    w = noise ? '1 : '0;
    w[61:60] = k[4:3];
    w[11:9]  = k[2:0];
    return w;
  endfunction

  function automatic logic [63:0] mkMask(input logic [4:0] k, input logic [1:0] pr,
                                         input logic fill);
    logic [63:0] m;
    m = fill ? '1 : '0;
    m[2*(31-int'(k)) +: 2] = pr;
    return m;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkRegs(input string tag);
    check({tag, " R7/R8 errCode"}, 64'(errCode), 64'(expErr));
    check({tag, " R6 dataStatus"}, 64'(dataStatus), 64'(expStatus));
    check({tag, " R7 faultAddr"}, faultAddr, expAddr);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (2) @(negedge clk);
    #1;
    checkRegs("R10 reset");
    @(negedge clk);
    rstN = 1'b1;

    // table walk: R1..R9
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      keyEnable  = VECS[i].en;
      reqValid   = VECS[i].valid;
      accessType = VECS[i].acc;
      pteWord    = mkPte(VECS[i].key, VECS[i].fill);
      maskReg    = mkMask(VECS[i].key, VECS[i].pair, VECS[i].fill);
      ppPerm     = VECS[i].pp;
      effAddr    = VECS[i].addr;
      #1;
      check($sformatf("R4 permOut vec%0d", i), 64'(permOut), 64'(VECS[i].expPerm));
      check($sformatf("R5 faultNow vec%0d", i), 64'(faultNow), 64'(VECS[i].expFault));
      if (VECS[i].expFault) begin
        if (VECS[i].acc == 2'd2) expErr = 32'h0800_0000;
        else begin
          expErr    = '0;
          expStatus = VECS[i].expStatus;
          expAddr   = VECS[i].addr;
        end
      end
      @(posedge clk);
      #1;
      checkRegs($sformatf("R9 vec%0d", i));
    end

    // R1/R2: every key selects its own pair, others filled opposite
    reqValid = 1'b0;
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      keyEnable = 1'b1;
      accessType = 2'd0;
      ppPerm  = 3'b111;
      pteWord = mkPte(5'(k), k[0]);
      maskReg = mkMask(5'(k), 2'b01, 1'b0);
      #1;
      check($sformatf("R2 read pair key%0d", k), 64'(permOut), 64'(3'b101));
      maskReg = mkMask(5'(k), 2'b10, 1'b1) & ~(64'h1 << (2*(31-k)));
      #1;
      check($sformatf("R1 write pair key%0d", k), 64'(permOut), 64'(3'b110));
    end

    // R3: key disabled with an all-zero mask still grants everything
    @(negedge clk);
    keyEnable = 1'b0;
    maskReg = '0;
    #1;
    check("R3 disabled grants all", 64'(permOut), 64'(3'b111));

    // R10: reset mid-run clears the captured state
    @(negedge clk);
    rstN = 1'b0;
    #1;
    expErr = '0; expStatus = '0; expAddr = '0;
    checkRegs("R10 mid reset");
    @(negedge clk);
    rstN = 1'b1;

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule